// File: doc/BRIEF.md
# Condition Code Branch Evaluator

This block resolves a single-byte branch opcode into a next program counter. It covers the conditional branches that test the four condition flags (negative, zero, overflow, carry), two unconditional branches and two subroutine branches. For each accepted opcode it reports whether the branch is taken and the resulting next PC. For a subroutine branch it also issues a stack push request, which carries the return PC and the decremented stack pointer.

The caller presents the opcode, the flags, the PC of the following instruction, a 16-bit displacement field and the current stack pointer. It marks the cycle with `op_valid`. One clock later the registered results appear with `res_valid`. The condition flags are returned unchanged. Opcodes outside the supported set raise an illegal flag, and the PC then stays where it was.

Flag vector encoding: `flags_in[3]` = N, `flags_in[2]` = Z, `flags_in[1]` = V, `flags_in[0]` = C. Opcodes that use an 8-bit displacement read only `disp_in[7:0]`.

Top module: `bre_branch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `res_valid`, `taken`, `illegal` and `push_req` are all 0.
- R2: Signed tests: opcode 0x14 is taken when (N|Z)=0, 0x15 when (N|Z)=1, 0x18 when N=0, and 0x19 when N=1.
- R3: Equality tests: opcode 0x12 is taken when Z=0 and 0x13 when Z=1.
- R4: Unsigned, carry and overflow tests: 0x1A is taken when (C|Z)=0, 0x1B when (C|Z)=1, 0x1C when V=0, 0x1D when V=1, 0x1E when C=0 and 0x1F when C=1.
- R5: Opcode 0x11 is always taken and uses the sign-extended `disp_in[7:0]`, ignoring `disp_in[15:8]`. Opcode 0x31 is always taken and uses the sign-extended `disp_in[15:0]`. All conditional opcodes use the 8-bit form.
- R6: A taken branch gives `next_pc` = `pc_in` + the sign-extended displacement, modulo 2^32. A branch that is not taken gives `next_pc` = `pc_in`.
- R7: Opcodes 0x10 (8-bit displacement) and 0x30 (16-bit displacement) are taken and assert `push_req`, with `sp_out` = `push_addr` = `sp_in` − 4 and `push_data` = `pc_in`.
- R8: `flags_out` equals the `flags_in` sampled with the opcode, whatever the opcode.
- R9: Any other opcode, including 0x16, 0x17 and 0x32, sets `illegal`, clears `taken` and `push_req`, and gives `next_pc` = `pc_in`.
- R10: Results appear exactly one cycle after `op_valid`. A cycle without `op_valid` yields `res_valid`, `taken`, `illegal` and `push_req` all 0.
- R11: For every opcode other than 0x10 and 0x30, `push_req` = 0 and `sp_out` = `sp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode and operands valid this cycle |
| opcode | input | 8 | Branch opcode |
| flags_in | input | 4 | Condition flags {N,Z,V,C} |
| pc_in | input | 32 | PC of the next instruction |
| disp_in | input | 16 | Displacement field |
| sp_in | input | 32 | Current stack pointer |
| res_valid | output | 1 | Results valid |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Opcode not supported |
| next_pc | output | 32 | Resolved next PC |
| flags_out | output | 4 | Condition flags, unchanged |
| push_req | output | 1 | Stack write request |
| push_addr | output | 32 | Stack write address |
| push_data | output | 32 | Stack write data (return PC) |
| sp_out | output | 32 | Updated stack pointer |

## Verification
The stack push and the PC redirect happen in the same result cycle for a subroutine branch, so the return address and the target must both be correct together. The bench issues 0x10 and 0x30 with positive and negative displacements and a stack pointer near zero, which forces wrap-around. In that single output cycle it compares `push_addr`, `push_data`, `sp_out` and `next_pc` against independently computed values. Back-to-back issues with different opcodes confirm that a push request never lingers into a following non-call result.

// File: rtl/bre_pkg.sv
package bre_pkg;

    typedef enum logic [1:0] {
        KIND_ILLEGAL,
        KIND_COND,
        KIND_JUMP,
        KIND_CALL
    } op_kind_e;

    typedef enum logic [2:0] {
        SEL_Z,
        SEL_N_OR_Z,
        SEL_N,
        SEL_C_OR_Z,
        SEL_V,
        SEL_C,
        SEL_NONE
    } cond_sel_e;

    typedef struct packed {
        op_kind_e  kind;
        cond_sel_e sel;
        logic      polarity;
        logic      wide;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/bre_decode.sv
module bre_decode
    import bre_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    logic [3:0] hi_nib;
    logic [3:0] lo_nib;

    always_comb begin
        hi_nib       = opcode[7:4];
        lo_nib       = opcode[3:0];
        dec.kind     = KIND_ILLEGAL;
        dec.sel      = SEL_NONE;
        dec.polarity = opcode[0];
        dec.wide     = 1'b0;
        if (hi_nib == 4'h1 || hi_nib == 4'h3) begin
            dec.wide = hi_nib[1];
            if (lo_nib == 4'h0) begin
                dec.kind = KIND_CALL;
            end else if (lo_nib == 4'h1) begin
                dec.kind = KIND_JUMP;
            end else if (hi_nib == 4'h1) begin
                dec.kind = KIND_COND;
                case (opcode[3:1])
                    3'd1:    dec.sel = SEL_Z;
                    3'd2:    dec.sel = SEL_N_OR_Z;
                    3'd4:    dec.sel = SEL_N;
                    3'd5:    dec.sel = SEL_C_OR_Z;
                    3'd6:    dec.sel = SEL_V;
                    3'd7:    dec.sel = SEL_C;
                    default: dec.kind = KIND_ILLEGAL;
                endcase
            end
        end
    end

endmodule

// File: rtl/bre_cond_eval.sv
module bre_cond_eval
    import bre_pkg::*;
(
    input  flags_t    flags,
    input  cond_sel_e sel,
    input  logic      polarity,
    output logic      met
);

    logic level;

    always_comb begin
        case (sel)
            SEL_Z:      level = flags.z;
            SEL_N_OR_Z: level = flags.n | flags.z;
            SEL_N:      level = flags.n;
            SEL_C_OR_Z: level = flags.c | flags.z;
            SEL_V:      level = flags.v;
            SEL_C:      level = flags.c;
            default:    level = 1'b0;
        endcase
        met = (sel != SEL_NONE) && (level == polarity);
    end

endmodule

// File: rtl/bre_target.sv
module bre_target #(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              wide,
    output logic [ADDR_W-1:0] target
);

    localparam int SHORT_PAD = ADDR_W - SHORT_W;
    localparam int LONG_PAD  = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] long_ext;

    always_comb begin
        short_ext = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        long_ext  = {{LONG_PAD{disp[DISP_W-1]}}, disp};
        target    = pc + (wide ? long_ext : short_ext);
    end

endmodule

// File: rtl/bre_branch_unit.sv
module bre_branch_unit
    import bre_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 16,
    parameter int SHORT_W    = 8,
    parameter int PUSH_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [3:0]        flags_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DISP_W-1:0] disp_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              res_valid,
    output logic              taken,
    output logic              illegal,
    output logic [ADDR_W-1:0] next_pc,
    output logic [3:0]        flags_out,
    output logic              push_req,
    output logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] push_data,
    output logic [ADDR_W-1:0] sp_out
);

    localparam logic [ADDR_W-1:0] PUSH_STEP = ADDR_W'(PUSH_BYTES);

    typedef struct packed {
        logic              vld;
        logic              taken;
        logic              illegal;
        logic              push;
        logic [ADDR_W-1:0] next_pc;
        logic [3:0]        flags;
        logic [ADDR_W-1:0] push_addr;
        logic [ADDR_W-1:0] push_data;
        logic [ADDR_W-1:0] sp;
    } res_t;

    dec_t              dec;
    logic              cond_met;
    logic [ADDR_W-1:0] target;
    res_t              res_d;
    res_t              res_q;

    bre_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    bre_cond_eval u_cond (
        .flags    (flags_t'(flags_in)),
        .sel      (dec.sel),
        .polarity (dec.polarity),
        .met      (cond_met)
    );

    bre_target #(
        .ADDR_W  (ADDR_W),
        .DISP_W  (DISP_W),
        .SHORT_W (SHORT_W)
    ) u_target (
        .pc     (pc_in),
        .disp   (disp_in),
        .wide   (dec.wide),
        .target (target)
    );

    always_comb begin
        logic go;
        logic call;
        call = (dec.kind == KIND_CALL);
        case (dec.kind)
            KIND_COND: go = cond_met;
            KIND_JUMP: go = 1'b1;
            KIND_CALL: go = 1'b1;
            default:   go = 1'b0;
        endcase
        res_d.vld       = op_valid;
        res_d.taken     = op_valid && go;
        res_d.illegal   = op_valid && (dec.kind == KIND_ILLEGAL);
        res_d.push      = op_valid && call;
        res_d.next_pc   = go ? target : pc_in;
        res_d.flags     = flags_in;
        res_d.push_addr = sp_in - PUSH_STEP;
        res_d.push_data = pc_in;
        res_d.sp        = call ? (sp_in - PUSH_STEP) : sp_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.vld;
    assign taken     = res_q.taken;
    assign illegal   = res_q.illegal;
    assign push_req  = res_q.push;
    assign next_pc   = res_q.next_pc;
    assign flags_out = res_q.flags;
    assign push_addr = res_q.push_addr;
    assign push_data = res_q.push_data;
    assign sp_out    = res_q.sp;

    // R10
    strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken || illegal || push_req) |-> res_valid);

    // R10
    valid_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(op_valid)));

    // R9
    illegal_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!taken && !push_req));

    // R6
    not_taken_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> (next_pc == $past(pc_in)));

    // R7
    push_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (taken && push_addr == sp_out && push_data == $past(pc_in)
                      && sp_out == $past(sp_in) - PUSH_STEP));

    // R11
    no_push_sp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !push_req) |-> (sp_out == $past(sp_in)));

    // R8
    flags_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags_out == $past(flags_in)));

endmodule

// File: tb/bre_branch_unit_test.sv
`timescale 1ns/1ps
module bre_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [3:0]  flags_in = 4'h0;
    logic [31:0] pc_in = 32'h0;
    logic [15:0] disp_in = 16'h0;
    logic [31:0] sp_in = 32'h0;
    logic        res_valid, taken, illegal, push_req;
    logic [31:0] next_pc, push_addr, push_data, sp_out;
    logic [3:0]  flags_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bre_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .flags_in(flags_in), .pc_in(pc_in), .disp_in(disp_in), .sp_in(sp_in),
        .res_valid(res_valid), .taken(taken), .illegal(illegal),
        .next_pc(next_pc), .flags_out(flags_out), .push_req(push_req),
        .push_addr(push_addr), .push_data(push_data), .sp_out(sp_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: is opcode taken, is it known, wide, call
    function automatic void model(input logic [7:0] op, input logic [3:0] f,
                                  output bit known, output bit go,
                                  output bit wide, output bit call);
        bit n, z, v, c;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        known = 1; go = 0; wide = 0; call = 0;
        case (op)
            8'h12: go = !z;
            8'h13: go = z;
            8'h14: go = !(n | z);
            8'h15: go = n | z;
            8'h18: go = !n;
            8'h19: go = n;
            8'h1A: go = !(c | z);
            8'h1B: go = c | z;
            8'h1C: go = !v;
            8'h1D: go = v;
            8'h1E: go = !c;
            8'h1F: go = c;
            8'h11: go = 1;
            8'h31: begin go = 1; wide = 1; end
            8'h10: begin go = 1; call = 1; end
            8'h30: begin go = 1; call = 1; wide = 1; end
            default: known = 0;
        endcase
    endfunction

    task automatic issue(input string req, input logic [7:0] op, input logic [3:0] f,
                         input logic [31:0] pc, input logic [15:0] d,
                         input logic [31:0] sp);
        bit known, go, wide, call;
        logic [31:0] ext, exp_pc, exp_sp;
        model(op, f, known, go, wide, call);
        ext    = wide ? {{16{d[15]}}, d} : {{24{d[7]}}, d[7:0]};
        exp_pc = go ? pc + ext : pc;
        exp_sp = call ? sp - 32'd4 : sp;
        @(negedge clk);
        op_valid = 1'b1; opcode = op; flags_in = f; pc_in = pc; disp_in = d; sp_in = sp;
        @(posedge clk); #1;
        op_valid = 1'b0;
        check({req, " R10"}, "res_valid", 32'(res_valid), 32'd1);
        check(req, "taken", 32'(taken), 32'(go));
        check({req, " R9"}, "illegal", 32'(illegal), 32'(!known));
        check({req, " R6"}, "next_pc", next_pc, exp_pc);
        check({req, " R8"}, "flags_out", 32'(flags_out), 32'(f));
        check({req, " R11"}, "push_req", 32'(push_req), 32'(call));
        check({req, " R11"}, "sp_out", sp_out, exp_sp);
        if (call) begin
            check({req, " R7"}, "push_addr", push_addr, sp - 32'd4);
            check({req, " R7"}, "push_data", push_data, pc);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_valid = 1'b1; opcode = 8'h10;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "res_valid", 32'(res_valid), 32'd0);
        check("R1", "taken", 32'(taken), 32'd0);
        check("R1", "push_req", 32'(push_req), 32'd0);
        check("R1", "illegal", 32'(illegal), 32'd0);
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "res_valid after release", 32'(res_valid), 32'd0);
        check("R1", "push_req after release", 32'(push_req), 32'd0);
    endtask

    task automatic t_cond_group(input string req, input logic [7:0] ops[]);
        foreach (ops[i]) begin
            for (int f = 0; f < 16; f++) begin
                issue(req, ops[i], 4'(f), 32'h0000_1000 + 32'(f * 16), 16'h7F80 + 16'(f), 32'h0000_8000);
            end
        end
    endtask

    task automatic t_jump();
        issue("R5", 8'h11, 4'hF, 32'h0000_2000, 16'hAB7F, 32'h100);
        issue("R5", 8'h11, 4'h0, 32'h0000_2000, 16'h0080, 32'h100);
        issue("R5", 8'h31, 4'h5, 32'h0000_2000, 16'h8000, 32'h100);
        issue("R5", 8'h31, 4'hA, 32'hFFFF_FFF0, 16'h0020, 32'h100);
        issue("R6", 8'h31, 4'h0, 32'h0000_0004, 16'hFFF0, 32'h100);
    endtask

    task automatic t_call();
        issue("R7", 8'h10, 4'h3, 32'h0000_4000, 16'h12FC, 32'h0000_7F00);
        issue("R7", 8'h30, 4'hC, 32'h0000_4000, 16'h7FFF, 32'h0000_7F00);
        issue("R7", 8'h30, 4'h0, 32'h0001_0000, 16'hC000, 32'h0000_0002);
        issue("R7", 8'h10, 4'hF, 32'h8000_0000, 16'h0001, 32'h0000_0000);
        issue("R11", 8'h12, 4'h0, 32'h0000_4000, 16'h0010, 32'h0000_7F00);
    endtask

    task automatic t_illegal();
        logic [7:0] bad[] = '{8'h16, 8'h17, 8'h32, 8'h3F, 8'h20, 8'h00, 8'hFF, 8'h1_0 ^ 8'h80};
        foreach (bad[i]) issue("R9", bad[i], 4'hF, 32'h0000_5550, 16'h0040, 32'h200);
    endtask

    task automatic t_idle();
        issue("R10", 8'h30, 4'h0, 32'h100, 16'h10, 32'h400);
        @(posedge clk); #1;
        check("R10", "idle res_valid", 32'(res_valid), 32'd0);
        check("R10", "idle push_req", 32'(push_req), 32'd0);
        check("R10", "idle taken", 32'(taken), 32'd0);
        check("R10", "idle illegal", 32'(illegal), 32'd0);
    endtask

    initial begin
        t_reset();
        t_cond_group("R2", '{8'h14, 8'h15, 8'h18, 8'h19});
        t_cond_group("R3", '{8'h12, 8'h13});
        t_cond_group("R4", '{8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h1F});
        t_jump();
        t_call();
        t_illegal();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule